// File: doc/BRIEF.md
# Split-Address Pipelined Request Encoder

This block sits on the master side of a pipelined request bus whose address/data lane is 32 bits wide and whose command lane is 4 bits wide. It takes one queued access request at a time: a quadword-aligned 64-bit address, a 3-bit length code and a 4-bit command. It turns that request into one or two registered bus words, and it raises a strobe on every word it drives.

If the upper half of the address is zero, the request fits in one word. The low address and the length share the address/data lane, and the command rides on the command lane. If any upper address bit is set, the block sends two words. The first word keeps the same lane layout but carries the escape code 4'b1101 in place of the command. The second word carries the upper address half together with the real command. Since every address is aligned to 8 bytes, its three lowest bits are never sent. The length code fills that slot instead.

A request is taken through a valid/ready handshake. It is taken only while the bus grant is held and the encoder is either idle or driving the final word of its current request. A held grant therefore lets requests follow one another with no gap. The request source must never use the escape code as a real command.

Top module: `pipe_req_encoder`

## Requirements
- R1: `req_ready` is high exactly when `gnt` is high and the encoder is not driving the first word of a two-word request. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and its first word appears on the bus one cycle later with `bus_strobe` high.
- R2: A request with address bits 63..32 all zero produces exactly one word: `bus_ad` = {address[31:3], length}, `bus_cbe` = the request command.
- R3: A request with any of address bits 63..32 set produces a first word of `bus_ad` = {address[31:3], length} and `bus_cbe` = 4'b1101.
- R4: The second word of a two-word request follows in the very next cycle, with `bus_ad` = address[63:32] and `bus_cbe` = the request command. It is driven whether or not `gnt` is still high.
- R5: Address bits 2..0 of the request have no effect on any bus output.
- R6: In every cycle without a request word (and during reset), `bus_strobe`, `bus_ad` and `bus_cbe` are all zero.
- R7: A request taken while the encoder drives a final word starts in the next cycle with no idle gap. No request is taken while the first word of a two-word request is on the bus.
- R8: The length code is placed unchanged in `bus_ad[2:0]` for all eight codes (code n means n+1 units of 8 bytes).
- R9: While `gnt` is low, no request is taken, and no new request word appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gnt | input | 1 | Bus grant; new requests start only while it is held |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Encoder takes the request at this edge |
| req_addr | input | 64 | Quadword-aligned request address |
| req_len | input | 3 | Length code, 8-byte units minus one |
| req_cmd | input | 4 | Access command; must not be 4'b1101 |
| bus_ad | output | 32 | Registered address/data lane word |
| bus_cbe | output | 4 | Registered command lane word |
| bus_strobe | output | 1 | High on every cycle that drives a request word |

## Verification
Two functions can fall in the same cycle: the encoder finishes the last word of one request while it takes the next request. A final word may be a lone short-address word or the upper-half word of a long request. The bench holds the grant and keeps `req_valid` high across many such boundaries, mixing short and long addresses at random, and adds directed back-to-back pairs. It judges each boundary in two ways. `req_ready` must be high during the final word and low during an escape word. The next cycle must carry the new first word with no gap, and that word is compared with a bench model of the lane layout.

// File: rtl/pre_pkg.sv
package pre_pkg;

    localparam logic [3:0] PRE_ESC_CODE = 4'b1101;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SOLO = 2'd1,
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

endpackage

// File: rtl/pre_hi_detect.sv
module pre_hi_detect #(
    parameter int ADDR_W  = 64,
    parameter int BUS_W   = 32,
    parameter int CHUNK_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_long
);
    localparam int HI_W    = ADDR_W - BUS_W;
    localparam int N_CHUNK = (HI_W + CHUNK_W - 1) / CHUNK_W;
    localparam int PAD_W   = N_CHUNK * CHUNK_W;

    logic [PAD_W-1:0]   hi_pad;
    logic [N_CHUNK-1:0] chunk_any;

    assign hi_pad = PAD_W'(addr[ADDR_W-1:BUS_W]);

    for (genvar g = 0; g < N_CHUNK; g++) begin : g_chunk
        assign chunk_any[g] = |hi_pad[g*CHUNK_W +: CHUNK_W];
    end

    assign is_long = |chunk_any;
endmodule

// File: rtl/pre_word_fmt.sv
module pre_word_fmt #(
    parameter int ADDR_W = 64,
    parameter int BUS_W  = 32,
    parameter int LEN_W  = 3,
    parameter int CMD_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              is_long,
    output logic [BUS_W-1:0]  w0_ad,
    output logic [CMD_W-1:0]  w0_cbe,
    output logic [BUS_W-1:0]  w1_ad,
    output logic [CMD_W-1:0]  w1_cbe
);
    import pre_pkg::*;

    // Low word: quadword address bits replace the byte offset by the length
    assign w0_ad  = {addr[BUS_W-1:LEN_W], len};
    assign w0_cbe = is_long ? CMD_W'(PRE_ESC_CODE) : cmd;
    assign w1_ad  = BUS_W'(addr[ADDR_W-1:BUS_W]);
    assign w1_cbe = cmd;
endmodule

// File: rtl/pipe_req_encoder.sv
module pipe_req_encoder #(
    parameter int ADDR_W = 64,
    parameter int BUS_W  = 32,
    parameter int LEN_W  = 3,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnt,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CMD_W-1:0]  req_cmd,
    output logic [BUS_W-1:0]  bus_ad,
    output logic [CMD_W-1:0]  bus_cbe,
    output logic              bus_strobe
);
    import pre_pkg::*;

    localparam logic [CMD_W-1:0] ESC = CMD_W'(PRE_ESC_CODE);

    typedef struct packed {
        phase_e           ph;
        logic             stb;
        logic [BUS_W-1:0] ad;
        logic [CMD_W-1:0] cbe;
        logic [BUS_W-1:0] hi_ad;
        logic [CMD_W-1:0] hi_cbe;
    } enc_state_t;

    enc_state_t s_d, s_q;

    logic             is_long;
    logic [BUS_W-1:0] w0_ad, w1_ad;
    logic [CMD_W-1:0] w0_cbe, w1_cbe;
    logic             take;

    pre_hi_detect #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .CHUNK_W(8)
    ) u_hi (
        .addr   (req_addr),
        .is_long(is_long)
    );

    pre_word_fmt #(
        .ADDR_W(ADDR_W),
        .BUS_W (BUS_W),
        .LEN_W (LEN_W),
        .CMD_W (CMD_W)
    ) u_fmt (
        .addr   (req_addr),
        .len    (req_len),
        .cmd    (req_cmd),
        .is_long(is_long),
        .w0_ad  (w0_ad),
        .w0_cbe (w0_cbe),
        .w1_ad  (w1_ad),
        .w1_cbe (w1_cbe)
    );

    // Ready in idle or on a final word (lone word or upper half)
    assign req_ready = gnt && (s_q.ph != PH_LOW);
    assign take      = req_valid && req_ready;

    always_comb begin
        s_d = s_q;
        if (s_q.ph == PH_LOW) begin
            s_d.ph  = PH_HIGH;
            s_d.stb = 1'b1;
            s_d.ad  = s_q.hi_ad;
            s_d.cbe = s_q.hi_cbe;
        end else if (take) begin
            s_d.ph     = is_long ? PH_LOW : PH_SOLO;
            s_d.stb    = 1'b1;
            s_d.ad     = w0_ad;
            s_d.cbe    = w0_cbe;
            s_d.hi_ad  = w1_ad;
            s_d.hi_cbe = w1_cbe;
        end else begin
            s_d.ph  = PH_IDLE;
            s_d.stb = 1'b0;
            s_d.ad  = '0;
            s_d.cbe = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, stb: 1'b0, ad: '0, cbe: '0, hi_ad: '0, hi_cbe: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_ad     = s_q.ad;
    assign bus_cbe    = s_q.cbe;
    assign bus_strobe = s_q.stb;

    AST_TAKE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_strobe); // R1
    AST_CMD_NOT_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (req_cmd != ESC)); // R1
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |-> (bus_ad == '0 && bus_cbe == '0)); // R6
    AST_ESC_THEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_cbe == ESC) |=>
            (bus_strobe && bus_cbe != ESC && bus_ad == $past(s_q.hi_ad))); // R4
    AST_NO_TAKE_ON_ESC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_cbe == ESC) |-> !req_ready); // R7
    AST_NO_GNT_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt && !(bus_strobe && bus_cbe == ESC)) |=> !bus_strobe); // R9
endmodule

// File: tb/pipe_req_encoder_tb.sv
`timescale 1ns/1ps
module pipe_req_encoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gnt = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [3:0]  req_cmd = '0;
    logic [31:0] bus_ad;
    logic [3:0]  bus_cbe;
    logic        bus_strobe;

    int n_chk = 0;
    int n_fail = 0;

    // model of the bus word expected after the next edge
    logic        m_stb = 1'b0;
    logic [31:0] m_ad = '0;
    logic [3:0]  m_cbe = '0;
    logic        m_pend = 1'b0;
    logic [31:0] m_hi_ad = '0;
    logic [3:0]  m_hi_cbe = '0;
    string       m_tag = "R6";

    always #4 clk = ~clk;

    pipe_req_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .gnt(gnt),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_cmd(req_cmd),
        .bus_ad(bus_ad), .bus_cbe(bus_cbe), .bus_strobe(bus_strobe)
    );

    function automatic logic [31:0] first_ad(logic [63:0] a, logic [2:0] l);
        return {a[31:3], l};
    endfunction

    function automatic logic [3:0] first_cbe(logic [63:0] a, logic [3:0] c);
        return (a[63:32] != 32'd0) ? 4'b1101 : c;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bus();
        logic [36:0] act, exp;
        act = {bus_strobe, bus_cbe, bus_ad};
        exp = {m_stb, m_cbe, m_ad};
        chk(act === exp, m_tag, 64'(act), 64'(exp));
    endtask

    // called at a negedge: check bus, drive inputs, check ready, advance model
    task automatic cycle(input logic g, input logic v, input logic [63:0] a,
                         input logic [2:0] l, input logic [3:0] c, input string xtag);
        logic exp_rdy;
        chk_bus();
        gnt = g; req_valid = v; req_addr = a; req_len = l; req_cmd = c;
        #1;
        exp_rdy = g && !m_pend;
        chk(req_ready === exp_rdy, g ? "R1" : "R9", 64'(req_ready), 64'(exp_rdy));
        if (m_pend) begin
            m_stb = 1'b1; m_ad = m_hi_ad; m_cbe = m_hi_cbe; m_pend = 1'b0;
            m_tag = {"R4", xtag};
        end else if (v && exp_rdy) begin
            m_stb    = 1'b1;
            m_ad     = first_ad(a, l);
            m_cbe    = first_cbe(a, c);
            m_pend   = (a[63:32] != 32'd0);
            m_hi_ad  = a[63:32];
            m_hi_cbe = c;
            m_tag    = {m_pend ? "R3" : "R2", xtag};
        end else begin
            m_stb = 1'b0; m_ad = '0; m_cbe = '0;
            m_tag = {"R6", xtag};
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [3:0] rnd_cmd();
        logic [3:0] c;
        c = 4'($urandom);
        if (c == 4'b1101) c = 4'b0110;
        return c;
    endfunction

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state: R6
        n_chk++;
        if ({bus_strobe, bus_cbe, bus_ad} !== 37'd0) begin
            n_fail++;
            $display("FAIL R6 actual=%h expected=0", {bus_strobe, bus_cbe, bus_ad});
        end
        rst_n = 1'b1;

        // R8 + R5: all length codes, low address bits varied, short address
        for (int i = 0; i < 8; i++)
            cycle(1'b1, 1'b1, {32'd0, 32'h1234_5670 | 32'(i)}, 3'(i), 4'h7, "/R8/R5");
        cycle(1'b1, 1'b0, '0, '0, '0, "");
        // R5: same fields except bits 2..0 give identical words
        cycle(1'b1, 1'b1, 64'h0000_0001_89AB_CDE8, 3'd2, 4'h3, "/R5");
        cycle(1'b1, 1'b0, '0, '0, '0, "");
        cycle(1'b1, 1'b1, 64'h0000_0001_89AB_CDEF, 3'd2, 4'h3, "/R5");
        cycle(1'b1, 1'b0, '0, '0, '0, "");
        // R4: long request, grant dropped during the escape word
        cycle(1'b1, 1'b1, 64'hDEAD_BEEF_0000_1000, 3'd7, 4'hA, "");
        cycle(1'b0, 1'b1, 64'h0, 3'd0, 4'h1, "/R9");
        cycle(1'b0, 1'b1, 64'h0, 3'd0, 4'h1, "/R9");
        cycle(1'b0, 1'b0, '0, '0, '0, "");
        // R7: back-to-back long, short, long, short with valid held
        cycle(1'b1, 1'b1, 64'h8000_0000_0000_0008, 3'd1, 4'h6, "/R7");
        cycle(1'b1, 1'b1, 64'h0000_0000_FFFF_FFF8, 3'd3, 4'h7, "/R7");
        cycle(1'b1, 1'b1, 64'h0000_0000_FFFF_FFF8, 3'd3, 4'h7, "/R7");
        cycle(1'b1, 1'b1, 64'h0000_0001_0000_0000, 3'd0, 4'hF, "/R7");
        cycle(1'b1, 1'b1, 64'h0000_0001_0000_0000, 3'd0, 4'hF, "/R7");
        cycle(1'b1, 1'b1, 64'h0000_0000_0000_0040, 3'd5, 4'h0, "/R7");
        cycle(1'b1, 1'b0, '0, '0, '0, "");
        cycle(1'b1, 1'b0, '0, '0, '0, "");

        // constrained random: mostly granted, half long addresses
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a;
            a[31:0]  = $urandom;
            a[63:32] = ($urandom % 2 == 0) ? 32'd0 : $urandom;
            cycle(($urandom % 8) != 0, ($urandom % 4) != 0, a, 3'($urandom), rnd_cmd(), "/R7");
        end
        cycle(1'b0, 1'b0, '0, '0, '0, "");
        cycle(1'b0, 1'b0, '0, '0, '0, "");
        chk_bus();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule